// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Front End

This block is the digital side of a 12-bit voltage-output converter. A host presents a 12-bit word on a parallel bus together with an active-low chip select and an active-low write strobe. When the write strobe returns high while chip select is low, the word is taken into a holding register. A separate active-low load strobe copies the holding register into the converter latch. The load strobe is level-sensitive: while it is low the latch keeps taking the holding register, so a system that ties it low gets a new output code after every write. The latch code drives the resistor string. The ideal output voltage is 2 × reference × code / 4096.

All strobes arrive asynchronously and are resampled in a fast system clock domain through two-flop synchronizers. The data word and chip select pass through a delay line one stage longer than the strobe synchronizer. Capture therefore uses the bus value from the last sample in which the write strobe was still low, which honours a zero hold time. An active-low power-down input clears a buffer-enable flag but leaves both registers intact. A sticky violation flag records writes made with chip select high and load pulses shorter than a minimum count of clock cycles.

Two state machines do the work. The write machine has the states WR_ARMED (strobe high, waiting) and WR_STROBED (strobe low seen). The transition from WR_STROBED to WR_ARMED on a synchronized rising edge either captures the word or, if chip select is high, raises a violation. The load machine has the states LD_SHUT (strobe high) and LD_OPEN (strobe low, latch transparent, width being counted). The transition from LD_OPEN to LD_SHUT checks the counted width.

Top module: `par_dac_front`

## Requirements
- R1: During and after reset, the latch code, buffer enable and violation flag are all zero, and the holding register is zero: a load pulse before any write leaves the code at 0x000.
- R2: A write made with chip select low stores the bus in the holding register, with bit 0 of `data_i` as the least significant code bit and bit 11 as the most significant.
- R3: A write strobe that rises while chip select is high leaves the holding register unchanged and sets the violation flag.
- R4: While the load strobe stays high, writes do not change the latch code.
- R5: A load pulse copies the most recent holding value into the latch code.
- R6: With the load strobe held low, the latch code follows every write within six clock cycles of the write strobe rising.
- R7: Buffer enable is 0 while `pd_n_i` is low and 1 while it is high, after the synchronizer delay.
- R8: Power-down does not alter the latch code, and after release the code is still the last latched value.
- R9: A load pulse lasting fewer than `LD_MIN_CYC` synchronized cycles (default 3) sets the violation flag; a pulse of exactly `LD_MIN_CYC` cycles does not.
- R10: The violation flag stays set through later valid traffic and is cleared only by reset.
- R11: A bus value that changes in the same instant the write strobe rises is not captured; the value present while the strobe was low is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for sampling |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| data_i | input | 12 | Parallel data word, bit 0 least significant |
| cs_n_i | input | 1 | Active-low chip select |
| we_n_i | input | 1 | Active-low write strobe, captured on its rising edge |
| ld_n_i | input | 1 | Active-low level-sensitive load strobe |
| pd_n_i | input | 1 | Active-low power-down |
| dac_code_o | output | 12 | Converter latch code |
| buf_en_o | output | 1 | Output buffer enable |
| viol_o | output | 1 | Sticky interface violation flag |

## Verification
The bench changes the bus at the same instant the write strobe rises. A design that samples the bus through the strobe synchronizer delay instead of the longer delay line would store the new, wrong word. It writes with chip select high and then pulses load. A design that qualifies capture badly would show the rejected word on the latch, and one that forgets the flag would leave the violation output low. It applies load pulses exactly at the minimum width and one cycle long, which exposes an off-by-one in the width counter as a missing or false violation. It also holds power-down low and checks that the latch code survives. A design that reset the latch on power-down would come back at zero.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    // Write strobe tracker: armed while strobe high, strobed once a low level is seen
    typedef enum logic [0:0] {
        WR_ARMED   = 1'b0,
        WR_STROBED = 1'b1
    } wr_state_e;

    // Load strobe tracker: shut while strobe high, open (transparent) while low
    typedef enum logic [0:0] {
        LD_SHUT = 1'b0,
        LD_OPEN = 1'b1
    } ld_state_e;

endpackage

// File: rtl/dac_pipe.sv
module dac_pipe #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/dac_wr_capture.sv
module dac_wr_capture
    import dacif_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n_s,
    input  logic              cs_n_d,
    input  logic [DATA_W-1:0] data_d,
    output logic [DATA_W-1:0] hold_o,
    output logic              bad_wr_o
);

    wr_state_e         state_q, state_d;
    logic              cap;
    logic [DATA_W-1:0] hold_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_ARMED;
        else        state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        state_d  = state_q;
        cap      = 1'b0;
        bad_wr_o = 1'b0;
        unique case (state_q)
            WR_ARMED: begin
                if (!we_n_s) state_d = WR_STROBED;
            end
            WR_STROBED: begin
                if (we_n_s) begin
                    state_d = WR_ARMED;
                    if (!cs_n_d) cap      = 1'b1;
                    else         bad_wr_o = 1'b1;
                end
            end
            default: state_d = WR_ARMED;
        endcase
    end

    // holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hold_q <= '0;
        else if (cap) hold_q <= data_d;
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/dac_ld_ctrl.sv
module dac_ld_ctrl
    import dacif_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int LD_MIN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n_s,
    input  logic [DATA_W-1:0] hold_i,
    output logic [DATA_W-1:0] code_o,
    output logic              short_o
);

    localparam int               CNT_W   = $clog2(LD_MIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LD_MIN_CYC);

    ld_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] code_q;

    // state register and width counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_SHUT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and width check
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        short_o = 1'b0;
        unique case (state_q)
            LD_SHUT: begin
                if (!ld_n_s) begin
                    state_d = LD_OPEN;
                    cnt_d   = CNT_W'(1);
                end
            end
            LD_OPEN: begin
                if (!ld_n_s) begin
                    if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
                end else begin
                    state_d = LD_SHUT;
                    cnt_d   = '0;
                    short_o = (cnt_q < CNT_MAX);
                end
            end
            default: state_d = LD_SHUT;
        endcase
    end

    // converter latch: transparent while the synchronized strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       code_q <= '0;
        else if (!ld_n_s) code_q <= hold_i;
    end

    assign code_o = code_q;

endmodule

// File: rtl/par_dac_front.sv
module par_dac_front #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int LD_MIN_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic              cs_n_i,
    input  logic              we_n_i,
    input  logic              ld_n_i,
    input  logic              pd_n_i,
    output logic [DATA_W-1:0] dac_code_o,
    output logic              buf_en_o,
    output logic              viol_o
);

    localparam int BUS_DLY = SYNC_STAGES + 1;
    localparam int BUS_W   = DATA_W + 1;

    logic [2:0]        ctrl_s;
    logic [BUS_W-1:0]  bus_d;
    logic [DATA_W-1:0] hold_q;
    logic              bad_wr;
    logic              ld_short;
    logic              viol_q;

    // strobes: {write, load, power-down}, idle levels at reset
    dac_pipe #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (3),
        .RST_VAL (3'b110)
    ) i_ctrl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({we_n_i, ld_n_i, pd_n_i}),
        .q_o   (ctrl_s)
    );

    // bus and chip select delayed one stage past the strobes
    dac_pipe #(
        .STAGES  (BUS_DLY),
        .WIDTH   (BUS_W),
        .RST_VAL ({1'b1, {DATA_W{1'b0}}})
    ) i_bus_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, data_i}),
        .q_o   (bus_d)
    );

    dac_wr_capture #(
        .DATA_W (DATA_W)
    ) i_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_n_s   (ctrl_s[2]),
        .cs_n_d   (bus_d[DATA_W]),
        .data_d   (bus_d[DATA_W-1:0]),
        .hold_o   (hold_q),
        .bad_wr_o (bad_wr)
    );

    dac_ld_ctrl #(
        .DATA_W     (DATA_W),
        .LD_MIN_CYC (LD_MIN_CYC)
    ) i_ld (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_n_s  (ctrl_s[1]),
        .hold_i  (hold_q),
        .code_o  (dac_code_o),
        .short_o (ld_short)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= viol_q | bad_wr | ld_short;
    end

    assign viol_o   = viol_q;
    assign buf_en_o = ctrl_s[0];

endmodule

// File: rtl/par_dac_front_chk.sv
module par_dac_front_chk #(
    parameter int DATA_W = 12,
    parameter int SYNC   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic              ld_n_i,
    input logic              pd_n_i,
    input logic [DATA_W-1:0] dac_code_o,
    input logic              buf_en_o,
    input logic              viol_o,
    input logic [DATA_W-1:0] hold_q
);

    localparam int WARM = SYNC + 3;

    int  cyc;
    logic warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cyc <= 0;
        else if (cyc < WARM) cyc <= cyc + 1;
    end
    assign warm = (cyc >= WARM);

    // R10
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(viol_o) |-> viol_o);

    // R7
    buf_en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (buf_en_o == $past(pd_n_i, SYNC)));

    // R3
    hold_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && hold_q != $past(hold_q)) |-> !$past(cs_n_i, SYNC + 2));

    // R4
    code_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$stable(dac_code_o)) |-> !$past(ld_n_i, SYNC + 1));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (dac_code_o == '0 && !viol_o && !buf_en_o));

endmodule

bind par_dac_front par_dac_front_chk #(
    .DATA_W (DATA_W),
    .SYNC   (SYNC_STAGES)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n_i),
    .ld_n_i     (ld_n_i),
    .pd_n_i     (pd_n_i),
    .dac_code_o (dac_code_o),
    .buf_en_o   (buf_en_o),
    .viol_o     (viol_o),
    .hold_q     (hold_q)
);

// File: tb/test_par_dac_front.sv
module test_par_dac_front;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;
    localparam int NVEC       = 8;

    // vector: {data[11:0], cs_n, pulse_load, expected code[11:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {12'h001, 1'b0, 1'b1, 12'h001},
        {12'h800, 1'b0, 1'b1, 12'h800},
        {12'hA5C, 1'b0, 1'b0, 12'h800},
        {12'h3C3, 1'b0, 1'b1, 12'h3C3},
        {12'hFFF, 1'b0, 1'b1, 12'hFFF},
        {12'h000, 1'b0, 1'b1, 12'h000},
        {12'h5A5, 1'b0, 1'b0, 12'h000},
        {12'h123, 1'b0, 1'b1, 12'h123}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] data_i = '0;
    logic        cs_n_i = 1'b1;
    logic        we_n_i = 1'b1;
    logic        ld_n_i = 1'b1;
    logic        pd_n_i = 1'b1;
    logic [11:0] dac_code_o;
    logic        buf_en_o;
    logic        viol_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    par_dac_front i_par_dac_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_i     (data_i),
        .cs_n_i     (cs_n_i),
        .we_n_i     (we_n_i),
        .ld_n_i     (ld_n_i),
        .pd_n_i     (pd_n_i),
        .dac_code_o (dac_code_o),
        .buf_en_o   (buf_en_o),
        .viol_o     (viol_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scramble: bus changes together with the rising write strobe
    task automatic write_word(input logic [11:0] d, input logic cs, input bit scramble);
        @(negedge clk);
        data_i = d;
        cs_n_i = cs;
        idle(1);
        we_n_i = 1'b0;
        idle(3);
        we_n_i = 1'b1;
        if (scramble) data_i = ~d;
        idle(4);
        cs_n_i = 1'b1;
    endtask

    task automatic pulse_load(input int n);
        @(negedge clk);
        ld_n_i = 1'b0;
        idle(n);
        ld_n_i = 1'b1;
        idle(6);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin : watchdog
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin : main
        // R1: state held in reset
        idle(3);
        check("R1 code in reset", dac_code_o, 0);
        check("R1 buf_en in reset", buf_en_o, 0);
        check("R1 viol in reset", viol_o, 0);
        rst_n = 1'b1;
        idle(4);
        pulse_load(4);
        check("R1 holding zero after reset", dac_code_o, 0);

        // table walk: R2, R4, R5
        for (int i = 0; i < NVEC; i++) begin
            write_word(VEC[i][25:14], VEC[i][13], 1'b0);
            if (VEC[i][12]) pulse_load(4);
            else            idle(6);
            check(VEC[i][12] ? "R5 load copies holding (R2 bit order)"
                             : "R4 no load keeps code",
                  dac_code_o, VEC[i][11:0]);
        end
        check("R9 valid pulses leave flag clear", viol_o, 0);

        // R11: bus changes with the rising strobe
        write_word(12'h456, 1'b0, 1'b1);
        pulse_load(4);
        check("R11 pre-edge value captured", dac_code_o, 12'h456);

        // R6: load held low
        @(negedge clk);
        ld_n_i = 1'b0;
        idle(4);
        write_word(12'h7E1, 1'b0, 1'b0);
        idle(2);
        check("R6 transparent follow first", dac_code_o, 12'h7E1);
        write_word(12'h0F0, 1'b0, 1'b0);
        idle(2);
        check("R6 transparent follow second", dac_code_o, 12'h0F0);
        ld_n_i = 1'b1;
        idle(6);

        // R7, R8: power-down
        pd_n_i = 1'b0;
        idle(4);
        check("R7 buffer off", buf_en_o, 0);
        check("R8 code kept in power-down", dac_code_o, 12'h0F0);
        pd_n_i = 1'b1;
        idle(4);
        check("R7 buffer back on", buf_en_o, 1);
        check("R8 code kept after release", dac_code_o, 12'h0F0);

        // R3: write with chip select high
        write_word(12'h999, 1'b1, 1'b0);
        check("R3 flag on deselected write", viol_o, 1);
        pulse_load(4);
        check("R3 holding unchanged", dac_code_o, 12'h0F0);

        // R10: sticky, cleared only by reset
        write_word(12'h222, 1'b0, 1'b0);
        pulse_load(4);
        check("R10 flag stays set", viol_o, 1);
        check("R5 load after violation", dac_code_o, 12'h222);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        check("R10 reset clears flag", viol_o, 0);
        check("R1 reset clears code", dac_code_o, 0);
        rst_n = 1'b1;
        idle(4);

        // R9: width boundary
        write_word(12'hABC, 1'b0, 1'b0);
        pulse_load(3);
        check("R9 minimum width accepted", viol_o, 0);
        check("R5 minimum pulse loads", dac_code_o, 12'hABC);
        pulse_load(1);
        check("R9 short pulse flagged", viol_o, 1);

        done = 1'b1;
        report();
        $finish;
    end

endmodule